// File: doc/BRIEF.md
# Block memory transfer sequencer

This block carries out the byte block-copy operations of a small processor. A start pulse loads a 16-bit source pointer, a 16-bit destination pointer and a 16-bit byte count, and a 2-bit mode selects the form of the operation. Each step reads one byte from the source address and writes it to the destination address. Both pointers then move by one, up or down depending on the mode, and the count drops by one. The single forms make exactly one step. The repeating forms keep stepping until the count reaches zero.

Memory is reached through a simple synchronous byte port. A read strobe presents an address, and the data comes back one cycle later. A write strobe carries the address and data together. The current pointer and count values stay visible on outputs, so the processor's register file can take them back. A one-cycle done pulse ends the operation. After every step that is not the last of a repeating form, a one-cycle repeat-pending pulse tells the fetch logic that the same instruction runs again, which the fetch logic treats as a program counter rewind of 2. A parity/overflow flag output reports whether the count is nonzero.

Top module: `blkcopy_seq`

## Requirements
- R1: While reset is low and after reset, no strobe is active; done, repeat_pend and all three flag outputs are 0; src_ptr, dst_ptr and cnt are 0.
- R2: The mode is sampled with start. Bit 1 selects the repeating form and bit 0 selects the decrementing form. This matches bits 4 and 3 of the opcode values A0 (single up), A8 (single down), B0 (repeat up) and B8 (repeat down), all hex.
- R3: Each step takes four cycles. In the first cycle mem_rd is high with mem_addr equal to src_ptr. The second cycle has no strobe. In the third cycle mem_wr is high with mem_addr equal to dst_ptr and mem_wdata equal to the byte read. The fourth cycle has no strobe. The first step begins in the cycle after start is sampled.
- R4: In the incrementing forms, both pointers rise by 1 at the end of each step, and 0xFFFF wraps to 0x0000.
- R5: In the decrementing forms, both pointers fall by 1 at the end of each step, and 0x0000 wraps to 0xFFFF.
- R6: cnt falls by 1 at the end of every step, with 16-bit wraparound. A single form makes exactly one step whatever the count.
- R7: A repeating form starts another step while the decremented count is nonzero. A count of 0 at start wraps to 0xFFFF and the transfer continues.
- R8: done is high for exactly one cycle, the cycle after the final step. repeat_pend is high for one cycle, the first cycle of each following step of a repeating form.
- R9: After each step, flag_pv equals 1 exactly when cnt is nonzero, and it holds that value until the next step. flag_h and flag_n are always 0.
- R10: start is ignored while a transfer is in progress: neither the mode, the pointers nor the count are reloaded.
- R11: A copy whose destination is one above its source replicates the first source byte across the destination range, because each byte is read after the previous write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| mode | input | 2 | Bit 1 repeat, bit 0 decrement |
| src_init | input | 16 | Source pointer loaded at start |
| dst_init | input | 16 | Destination pointer loaded at start |
| cnt_init | input | 16 | Byte count loaded at start |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read strobe; data valid the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after mem_rd |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| cnt | output | 16 | Current byte count |
| done | output | 1 | One-cycle end-of-operation pulse |
| repeat_pend | output | 1 | One-cycle pulse: instruction re-executes |
| flag_pv | output | 1 | Count nonzero after last step |
| flag_h | output | 1 | Half-carry flag, always 0 |
| flag_n | output | 1 | Add/subtract flag, always 0 |

## Verification
The bench goes after pointer wraparound in both directions. A design that got this wrong would carry into a seventeenth bit or stop at the boundary, so the copy would land at the wrong addresses. It starts a repeating form with a zero count. A design that tested the count before decrementing would end after one byte instead of continuing from 0xFFFF. It also runs an overlapping upward copy, which a design that prefetched source bytes ahead of its writes would copy verbatim instead of replicating. Finally, it pulses start in the middle of a transfer, which a design that reloaded its registers without checking its state would obey.

// File: rtl/blkcopy_pkg.sv
// Shared types for the block copy sequencer: step phases and mode fields.
package blkcopy_pkg;

    // Phases of one byte step, plus the idle phase.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WAIT   = 3'd2,
        ST_WRITE  = 3'd3,
        ST_UPDATE = 3'd4
    } bc_state_t;

    // Mode field positions (match opcode bits 4 and 3).
    localparam int MODE_DEC_BIT = 0;
    localparam int MODE_RPT_BIT = 1;

endpackage

// File: rtl/blkcopy_fsm.sv
// Step sequencer: walks idle -> read -> wait -> write -> update and
// loops for repeating forms. It also produces the registered done,
// repeat and parity/overflow outputs. It assumes cnt_next_nz reflects
// the count after the current step during the update phase.
module blkcopy_fsm
    import blkcopy_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      rpt,
    input  logic      cnt_next_nz,
    output bc_state_t state,
    output logic      load,
    output logic      step,
    output logic      done_q,
    output logic      rep_q,
    output logic      pv_q
);

    bc_state_t state_nx;
    logic      again;

    assign load  = (state == ST_IDLE) && start;
    assign step  = (state == ST_UPDATE);
    assign again = rpt && cnt_next_nz;

    // Next-phase selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (start) state_nx = ST_READ;
            ST_READ:   state_nx = ST_WAIT;
            ST_WAIT:   state_nx = ST_WRITE;
            ST_WRITE:  state_nx = ST_UPDATE;
            ST_UPDATE: state_nx = again ? ST_READ : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Registered pulses and the count-nonzero flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            rep_q  <= 1'b0;
            pv_q   <= 1'b0;
        end else begin
            done_q <= step && !again;
            rep_q  <= step && again;
            if (step) pv_q <= cnt_next_nz;
        end
    end

endmodule

// File: rtl/blkcopy_regs.sv
// Pointer and count registers. Both pointers load at start and move by
// one per step in the chosen direction; the count loads at start and
// falls by one per step. All arithmetic wraps at the register width.
module blkcopy_regs #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          dec,
    input  logic [AW-1:0] src_init,
    input  logic [AW-1:0] dst_init,
    input  logic [CW-1:0] cnt_init,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output logic          cnt_next_nz
);

    localparam int            NPTR  = 2;
    localparam logic [AW-1:0] ONE_A = AW'(1);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    logic [AW-1:0] ptr_q    [NPTR];
    logic [AW-1:0] ptr_init [NPTR];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;

    assign ptr_init[0] = src_init;
    assign ptr_init[1] = dst_init;

    // One identical up/down pointer per index.
    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        // Load or step this pointer.
        always_ff @(posedge clk) begin
            if (!rst_n)    ptr_q[i] <= '0;
            else if (load) ptr_q[i] <= ptr_init[i];
            else if (step) ptr_q[i] <= dec ? (ptr_q[i] - ONE_A) : (ptr_q[i] + ONE_A);
        end
    end

    assign cnt_nx      = cnt_q - ONE_C;
    assign cnt_next_nz = (cnt_nx != '0);

    // Load or decrement the byte count.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= cnt_init;
        else if (step) cnt_q <= cnt_nx;
    end

    assign src = ptr_q[0];
    assign dst = ptr_q[1];
    assign cnt = cnt_q;

endmodule

// File: rtl/blkcopy_port.sv
// Memory port driver: picks the address by phase, raises the strobes,
// and captures the read byte in the wait phase (one-cycle latency).
module blkcopy_port
    import blkcopy_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bc_state_t     state,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic          rd,
    output logic          wr,
    output logic [DW-1:0] wdata
);

    logic [DW-1:0] data_q;

    assign rd    = (state == ST_READ);
    assign wr    = (state == ST_WRITE);
    assign addr  = wr ? dst : src;
    assign wdata = data_q;

    // Hold the byte returned for the read of this step.
    always_ff @(posedge clk) begin
        if (!rst_n)                 data_q <= '0;
        else if (state == ST_WAIT)  data_q <= rdata;
    end

endmodule

// File: rtl/blkcopy_seq.sv
// Top of the block copy sequencer. Latches the mode at start and ties
// the phase sequencer, register set and memory port together. Assumes
// memory returns read data exactly one cycle after the read strobe.
module blkcopy_seq
    import blkcopy_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] src_init,
    input  logic [AW-1:0] dst_init,
    input  logic [CW-1:0] cnt_init,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic [CW-1:0] cnt,
    output logic          done,
    output logic          repeat_pend,
    output logic          flag_pv,
    output logic          flag_h,
    output logic          flag_n
);

    bc_state_t  st;
    logic       load;
    logic       step;
    logic       cnt_next_nz;
    logic [1:0] mode_q;

    // Capture the operation form when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= '0;
        else if (load) mode_q <= mode;
    end

    blkcopy_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rpt         (mode_q[MODE_RPT_BIT]),
        .cnt_next_nz (cnt_next_nz),
        .state       (st),
        .load        (load),
        .step        (step),
        .done_q      (done),
        .rep_q       (repeat_pend),
        .pv_q        (flag_pv)
    );

    blkcopy_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .step        (step),
        .dec         (mode_q[MODE_DEC_BIT]),
        .src_init    (src_init),
        .dst_init    (dst_init),
        .cnt_init    (cnt_init),
        .src         (src_ptr),
        .dst         (dst_ptr),
        .cnt         (cnt),
        .cnt_next_nz (cnt_next_nz)
    );

    blkcopy_port #(.AW(AW), .DW(DW)) u_port (
        .clk   (clk),
        .rst_n (rst_n),
        .state (st),
        .src   (src_ptr),
        .dst   (dst_ptr),
        .rdata (mem_rdata),
        .addr  (mem_addr),
        .rd    (mem_rd),
        .wr    (mem_wr),
        .wdata (mem_wdata)
    );

    assign flag_h = 1'b0;
    assign flag_n = 1'b0;

endmodule

// File: rtl/blkcopy_seq_chk.sv
// Property checker for the block copy sequencer, bound to the top.
module blkcopy_seq_chk
    import blkcopy_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input bc_state_t     st,
    input logic [1:0]    mode_q,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] src_ptr,
    input logic [AW-1:0] dst_ptr,
    input logic [CW-1:0] cnt,
    input logic          done,
    input logic          repeat_pend,
    input logic          flag_pv
);

    localparam logic [CW-1:0] ONE_C = CW'(1);
    localparam logic [AW-1:0] ONE_A = AW'(1);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R3
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && !mem_wr) ##1 mem_wr);

    // R3
    rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr == src_ptr));

    // R3
    wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == dst_ptr));

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> (cnt == $past(cnt) || cnt == $past(cnt) - ONE_C));

    // R4
    src_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> (src_ptr == $past(src_ptr) ||
                             src_ptr == $past(src_ptr) + ONE_A ||
                             src_ptr == $past(src_ptr) - ONE_A));

    // R10
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && start) |=> $stable(mode_q));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    rep_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_pend |-> (mem_rd && cnt != '0));

    // R7
    rpt_ends_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q[MODE_RPT_BIT]) |-> (cnt == '0));

    // R9
    pv_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_pv == (cnt != '0)));

endmodule

bind blkcopy_seq blkcopy_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .st          (st),
    .mode_q      (mode_q),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .src_ptr     (src_ptr),
    .dst_ptr     (dst_ptr),
    .cnt         (cnt),
    .done        (done),
    .repeat_pend (repeat_pend),
    .flag_pv     (flag_pv)
);

// File: tb/blkcopy_seq_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus
// memory-content checks after each transfer.
module blkcopy_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0;
    logic [15:0] mem_addr, src_ptr, dst_ptr, cnt;
    logic        mem_rd, mem_wr, done, repeat_pend, flag_pv, flag_h, flag_n;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    blkcopy_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .src_init(src_init), .dst_init(dst_init), .cnt_init(cnt_init),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .src_ptr(src_ptr), .dst_ptr(dst_ptr), .cnt(cnt),
        .done(done), .repeat_pend(repeat_pend),
        .flag_pv(flag_pv), .flag_h(flag_h), .flag_n(flag_n)
    );

    // Memory: sparse store over a computed background pattern.
    logic [7:0] mem_q [int];

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] rdm(input logic [15:0] a);
        if (mem_q.exists(int'(a))) return mem_q[int'(a)];
        return pat(a);
    endfunction

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= rdm(mem_addr);
        if (mem_wr) mem_q[int'(mem_addr)] = mem_wdata;
    end

    // Reference model.
    int          ph;
    logic [15:0] m_src, m_dst, m_cnt;
    logic        m_dec, m_rpt, m_done, m_rep, m_pv;
    logic [7:0]  m_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; m_src = 0; m_dst = 0; m_cnt = 0;
            m_dec = 0; m_rpt = 0; m_done = 0; m_rep = 0; m_pv = 0; m_data = 0;
        end else begin
            m_done = 0;
            m_rep  = 0;
            if (ph == 0) begin
                if (start) begin
                    m_src = src_init; m_dst = dst_init; m_cnt = cnt_init;
                    m_rpt = mode[1]; m_dec = mode[0];
                    ph = 1;
                end
            end else if (ph == 1) begin
                m_data = rdm(m_src);
                ph = 2;
            end else if (ph == 2) begin
                ph = 3;
            end else if (ph == 3) begin
                ph = 4;
            end else begin
                m_cnt = m_cnt - 16'd1;
                if (m_dec) begin m_src = m_src - 16'd1; m_dst = m_dst - 16'd1; end
                else       begin m_src = m_src + 16'd1; m_dst = m_dst + 16'd1; end
                m_pv = (m_cnt != 0);
                if (m_rpt && m_cnt != 0) begin m_rep = 1; ph = 1; end
                else begin m_done = 1; ph = 0; end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the edge.
    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            chk(mem_rd == (ph == 1), "R3", "mem_rd", 32'(mem_rd), 32'(ph == 1));
            chk(mem_wr == (ph == 3), "R3", "mem_wr", 32'(mem_wr), 32'(ph == 3));
            if (ph == 1) chk(mem_addr == m_src, "R3", "read addr", 32'(mem_addr), 32'(m_src));
            if (ph == 3) begin
                chk(mem_addr == m_dst, "R3", "write addr", 32'(mem_addr), 32'(m_dst));
                chk(mem_wdata == m_data, "R3", "write data", 32'(mem_wdata), 32'(m_data));
            end
            chk(src_ptr == m_src, "R4", "src_ptr", 32'(src_ptr), 32'(m_src));
            chk(dst_ptr == m_dst, "R5", "dst_ptr", 32'(dst_ptr), 32'(m_dst));
            chk(cnt == m_cnt, "R6", "cnt", 32'(cnt), 32'(m_cnt));
            chk(done == m_done, "R8", "done", 32'(done), 32'(m_done));
            chk(repeat_pend == m_rep, "R8", "repeat_pend", 32'(repeat_pend), 32'(m_rep));
            chk(flag_pv == m_pv, "R9", "flag_pv", 32'(flag_pv), 32'(m_pv));
            chk(!flag_h && !flag_n, "R9", "flag_h/flag_n", 32'({flag_h, flag_n}), 32'(0));
        end
    end

    task automatic kick(input logic [1:0] md, input logic [15:0] s,
                        input logic [15:0] d, input logic [15:0] c);
        @(negedge clk);
        mode = md; src_init = s; dst_init = d; cnt_init = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        @(posedge clk);
        cmp_en = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!mem_rd && !mem_wr && !done && !repeat_pend && !flag_pv,
            "R1", "idle outputs", 32'({mem_rd, mem_wr, done, repeat_pend, flag_pv}), 32'(0));
        chk(src_ptr == 0 && dst_ptr == 0 && cnt == 0, "R1", "regs zero",
            32'(src_ptr | dst_ptr | cnt), 32'(0));
        rst_n = 1'b1;

        // R2/R6: single up (A0) does one step despite count 5
        kick(2'b00, 16'h0010, 16'h0200, 16'd5);
        wait_done();
        chk(cnt == 16'd4 && src_ptr == 16'h0011, "R6", "single up one step",
            32'({src_ptr, cnt}), 32'({16'h0011, 16'd4}));
        chk(rdm(16'h0200) == pat(16'h0010), "R3", "single up byte",
            32'(rdm(16'h0200)), 32'(pat(16'h0010)));

        // R5/R9: single down (A8) from 0x0000 wraps, count hits 0
        kick(2'b01, 16'h0000, 16'h0300, 16'd1);
        wait_done();
        chk(src_ptr == 16'hFFFF && dst_ptr == 16'h02FF, "R5", "down wrap",
            32'({src_ptr, dst_ptr}), 32'({16'hFFFF, 16'h02FF}));
        chk(flag_pv == 1'b0, "R9", "pv clear at zero", 32'(flag_pv), 32'(0));

        // R7/R10: repeat up (B0) of 6 bytes with a stray start midway
        kick(2'b10, 16'h0020, 16'h0400, 16'd6);
        repeat (3) @(negedge clk);
        mode = 2'b01; src_init = 16'h7777; dst_init = 16'h8888; cnt_init = 16'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(src_ptr == 16'h0026 && cnt == 0, "R10", "stray start ignored",
            32'({src_ptr, cnt}), 32'({16'h0026, 16'h0000}));
        for (int i = 0; i < 6; i++)
            chk(rdm(16'h0400 + 16'(i)) == pat(16'h0020 + 16'(i)), "R7", "repeat up data",
                32'(rdm(16'h0400 + 16'(i))), 32'(pat(16'h0020 + 16'(i))));

        // R5: repeat down (B8) of 3 bytes
        kick(2'b11, 16'h0052, 16'h0502, 16'd3);
        wait_done();
        for (int i = 0; i < 3; i++)
            chk(rdm(16'h0500 + 16'(i)) == pat(16'h0050 + 16'(i)), "R5", "repeat down data",
                32'(rdm(16'h0500 + 16'(i))), 32'(pat(16'h0050 + 16'(i))));

        // R11: overlapping upward copy replicates the first byte
        kick(2'b10, 16'h0100, 16'h0101, 16'd4);
        wait_done();
        for (int i = 1; i <= 4; i++)
            chk(rdm(16'h0100 + 16'(i)) == pat(16'h0100), "R11", "overlap replicate",
                32'(rdm(16'h0100 + 16'(i))), 32'(pat(16'h0100)));

        // R4: upward copy across the top of the address space
        kick(2'b10, 16'hFFFE, 16'h0600, 16'd3);
        wait_done();
        chk(src_ptr == 16'h0001, "R4", "up wrap", 32'(src_ptr), 32'(16'h0001));
        chk(rdm(16'h0602) == pat(16'h0000), "R4", "byte from wrapped src",
            32'(rdm(16'h0602)), 32'(pat(16'h0000)));

        // R7: repeat with count 0 wraps and keeps going; stop by reset
        kick(2'b10, 16'h0700, 16'h0800, 16'd0);
        begin
            int reps = 0;
            while (reps < 5) begin
                @(negedge clk);
                if (repeat_pend) reps++;
                if (done) begin
                    chk(1'b0, "R7", "zero count ended early", 32'(cnt), 32'(16'hFFFB));
                    reps = 5;
                end
            end
        end
        chk(cnt == 16'hFFFB, "R7", "zero count wrapped", 32'(cnt), 32'(16'hFFFB));
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset mid-transfer returns to idle
        chk(!mem_rd && !mem_wr && cnt == 0 && src_ptr == 0, "R1", "reset mid-transfer",
            32'({mem_rd, mem_wr, cnt}), 32'(0));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule